// File: doc/BRIEF.md
# Stack Pointer Tracker

This unit sits in the decode stage and follows stack pointer changes so that they need no micro-ops of their own. Push, pop, call and return change a signed offset register held in the front end. The architectural stack pointer is left untouched. Every stack-relative memory access that passes through has its displacement corrected by that offset. The offset is folded back into the real register only when an instruction names the stack pointer explicitly, or when the offset register would otherwise wrap. In those cases a single sync micro-op is inserted that adds the offset to the architectural pointer, and the offset returns to zero.

Decoded instruction descriptors arrive on a valid/ready stream. Each descriptor carries a class, an operand size code, an explicit-stack-pointer flag, a base-is-stack-pointer flag, a signed displacement and an optional branch tag. Rewritten micro-ops leave on a registered valid/ready stream. Each branch stores the post-update offset under its tag. A flush names a tag, restores the offset from that entry and drops the micro-op waiting at the output.

Top module: `spt_tracker`

## Requirements
- R1: Push (class 1) and call (class 3) lower the offset by the operand size: code 0 means 2 bytes, code 1 means 4, codes 2 and 3 mean 8. The micro-op they emit carries the input displacement plus the lowered offset, and out_sync is 0.
- R2: Pop (class 2) and return (class 4) emit the input displacement plus the offset held before the instruction, then raise the offset by the operand size.
- R3: Any other class (0, or 5 to 7) leaves the offset unchanged. Its displacement has the offset added only when in_sp_base is 1; otherwise it passes unchanged.
- R4: A descriptor with in_sp_explicit set while the offset is nonzero is preceded by one micro-op with out_sync 1, out_kind 0 and out_disp equal to the sign-extended offset. The descriptor itself is then emitted as if the offset were zero.
- R5: After a sync micro-op the offset is zero.
- R6: With a zero offset, an explicit stack pointer descriptor produces no sync micro-op.
- R7: A push or pop that would take the offset outside the DELTA_W-bit signed range is preceded by a sync micro-op carrying the old offset, and is then processed from zero.
- R8: An accepted descriptor with in_is_branch set stores its post-update offset under in_br_tag. A flush_valid cycle restores the offset from the entry named by flush_tag, drops any micro-op held at the output and accepts no input.
- R9: The output holds its micro-op stable while out_ready is low, and in_ready is low then. A sync costs exactly one extra cycle before the descriptor is accepted.
- R10: After reset, out_valid is 0, in_ready is 1 and the offset is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Descriptor valid |
| in_ready | output | 1 | Descriptor accepted when high with in_valid |
| in_kind | input | 3 | Class: 0 other, 1 push, 2 pop, 3 call, 4 return |
| in_size | input | 2 | Operand size code (2, 4, 8, 8 bytes) |
| in_sp_explicit | input | 1 | Instruction reads or writes the stack pointer itself |
| in_sp_base | input | 1 | Memory access uses the stack pointer as base |
| in_disp | input | DISP_W | Signed displacement |
| in_is_branch | input | 1 | Descriptor is a branch to checkpoint |
| in_br_tag | input | TAG_W | Checkpoint slot for the branch |
| flush_valid | input | 1 | Misprediction recovery request |
| flush_tag | input | TAG_W | Checkpoint slot to restore |
| out_valid | output | 1 | Micro-op valid |
| out_ready | input | 1 | Consumer accepts micro-op |
| out_sync | output | 1 | Micro-op is a sync (adds out_disp to the stack pointer) |
| out_kind | output | 3 | Class of the micro-op |
| out_size | output | 2 | Operand size code |
| out_disp | output | DISP_W | Patched displacement, or offset for a sync |

## Verification
A descriptor accepted on one rising edge shows at the output after that edge and is consumed on the next edge when out_ready is high. A descriptor that needs a sync is accepted one edge later, because the sync takes the first edge. A flush takes effect at the edge that samples it, so the next descriptor already sees the restored offset. The bench changes inputs on falling edges, reads in_ready one nanosecond before the rising edge, and records output micro-ops on the falling edge before they are consumed. It counts the edges each descriptor takes to be accepted and compares that count with the one or two the requirements predict.

// File: rtl/spt_pkg.sv
package spt_pkg;

   typedef enum logic [2:0] {
      K_OTHER = 3'd0,
      K_PUSH  = 3'd1,
      K_POP   = 3'd2,
      K_CALL  = 3'd3,
      K_RET   = 3'd4
   } kind_e;

   // size code to byte count: 0 -> 2, 1 -> 4, otherwise 8
   function automatic logic [3:0] size_bytes(input logic [1:0] code);
      case (code)
         2'd0:    return 4'd2;
         2'd1:    return 4'd4;
         default: return 4'd8;
      endcase
   endfunction

endpackage

// File: rtl/spt_delta_calc.sv
module spt_delta_calc
   import spt_pkg::*;
#(
   parameter int DELTA_W = 12,
   parameter int DISP_W  = 16
) (
   input  logic [DELTA_W-1:0] delta,
   input  logic [2:0]         kind,
   input  logic [1:0]         size_code,
   input  logic               sp_explicit,
   input  logic               sp_base,
   input  logic [DISP_W-1:0]  disp,
   output logic               need_sync,
   output logic [DELTA_W-1:0] next_delta,
   output logic [DISP_W-1:0]  patched_disp
);
   localparam int EXT_W = DELTA_W + 1;
   localparam int PAD_W = DISP_W - DELTA_W;

   logic                    is_dec, is_inc, stack_op, ovf;
   logic signed [EXT_W-1:0] d_ext, step, moved;
   logic [DELTA_W-1:0]      addr_delta;

   always_comb begin
      is_dec   = (kind == K_PUSH) || (kind == K_CALL);
      is_inc   = (kind == K_POP)  || (kind == K_RET);
      stack_op = is_dec || is_inc;
      d_ext    = $signed({delta[DELTA_W-1], delta});
      step     = $signed({{(EXT_W-4){1'b0}}, size_bytes(size_code)});
      if (is_dec)      moved = d_ext - step;
      else if (is_inc) moved = d_ext + step;
      else             moved = d_ext;
      ovf        = moved[EXT_W-1] != moved[EXT_W-2];
      need_sync  = (delta != '0) && (sp_explicit || ovf);
      next_delta = moved[DELTA_W-1:0];
      addr_delta = is_dec ? moved[DELTA_W-1:0] : delta;
      if (stack_op || sp_base)
         patched_disp = disp + {{PAD_W{addr_delta[DELTA_W-1]}}, addr_delta};
      else
         patched_disp = disp;
   end

endmodule

// File: rtl/spt_ckpt_buf.sv
module spt_ckpt_buf #(
   parameter int DELTA_W = 12,
   parameter int DEPTH   = 4,
   parameter int TAG_W   = $clog2(DEPTH)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [TAG_W-1:0]   wr_tag,
   input  logic [DELTA_W-1:0] wr_val,
   input  logic [TAG_W-1:0]   rd_tag,
   output logic [DELTA_W-1:0] rd_val
);
   logic [DELTA_W-1:0] ent [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
      end else if (wr_en) begin
         ent[wr_tag] <= wr_val;
      end
   end

   assign rd_val = ent[rd_tag];

   // R8
   ckpt_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (ent[$past(wr_tag)] == $past(wr_val)));

endmodule

// File: rtl/spt_out_stage.sv
module spt_out_stage #(
   parameter int DISP_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              kill,
   input  logic              load,
   input  logic              ld_sync,
   input  logic [2:0]        ld_kind,
   input  logic [1:0]        ld_size,
   input  logic [DISP_W-1:0] ld_disp,
   output logic              can_load,
   input  logic              out_ready,
   output logic              out_valid,
   output logic              out_sync,
   output logic [2:0]        out_kind,
   output logic [1:0]        out_size,
   output logic [DISP_W-1:0] out_disp
);
   assign can_load = !out_valid || out_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_sync  <= 1'b0;
         out_kind  <= '0;
         out_size  <= '0;
         out_disp  <= '0;
      end else if (kill) begin
         out_valid <= 1'b0;
      end else if (load) begin
         out_valid <= 1'b1;
         out_sync  <= ld_sync;
         out_kind  <= ld_kind;
         out_size  <= ld_size;
         out_disp  <= ld_disp;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end

   // R9
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready && !kill) |=>
         (out_valid && $stable(out_disp) && $stable(out_sync) && $stable(out_kind)));

endmodule

// File: rtl/spt_tracker.sv
module spt_tracker
   import spt_pkg::*;
#(
   parameter int DELTA_W = 12,
   parameter int DISP_W  = 16,
   parameter int DEPTH   = 4,
   parameter int TAG_W   = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [2:0]        in_kind,
   input  logic [1:0]        in_size,
   input  logic              in_sp_explicit,
   input  logic              in_sp_base,
   input  logic [DISP_W-1:0] in_disp,
   input  logic              in_is_branch,
   input  logic [TAG_W-1:0]  in_br_tag,
   input  logic              flush_valid,
   input  logic [TAG_W-1:0]  flush_tag,
   output logic              out_valid,
   input  logic              out_ready,
   output logic              out_sync,
   output logic [2:0]        out_kind,
   output logic [1:0]        out_size,
   output logic [DISP_W-1:0] out_disp
);
   localparam int PAD_W = DISP_W - DELTA_W;

   generate
      if (DELTA_W < 5) begin : g_bad_delta
         $error("DELTA_W must hold the largest operand size with sign");
      end
      if (DISP_W <= DELTA_W) begin : g_bad_disp
         $error("DISP_W must be wider than DELTA_W");
      end
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two, at least 2");
      end
      if (TAG_W != $clog2(DEPTH)) begin : g_bad_tag
         $error("TAG_W must match DEPTH");
      end
   endgenerate

   logic [DELTA_W-1:0] delta, next_delta, ckpt_val;
   logic [DISP_W-1:0]  patched_disp, ld_disp;
   logic               need_sync, can_load, sync_fire, accept, load;

   spt_delta_calc #(.DELTA_W(DELTA_W), .DISP_W(DISP_W)) i_calc (
      .delta        (delta),
      .kind         (in_kind),
      .size_code    (in_size),
      .sp_explicit  (in_sp_explicit),
      .sp_base      (in_sp_base),
      .disp         (in_disp),
      .need_sync    (need_sync),
      .next_delta   (next_delta),
      .patched_disp (patched_disp)
   );

   spt_ckpt_buf #(.DELTA_W(DELTA_W), .DEPTH(DEPTH), .TAG_W(TAG_W)) i_ckpt (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (accept && in_is_branch),
      .wr_tag (in_br_tag),
      .wr_val (next_delta),
      .rd_tag (flush_tag),
      .rd_val (ckpt_val)
   );

   assign sync_fire = in_valid && can_load && !flush_valid && need_sync;
   assign in_ready  = can_load && !flush_valid && !need_sync;
   assign accept    = in_valid && in_ready;
   assign load      = sync_fire || accept;
   assign ld_disp   = sync_fire ? {{PAD_W{delta[DELTA_W-1]}}, delta} : patched_disp;

   spt_out_stage #(.DISP_W(DISP_W)) i_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .kill      (flush_valid),
      .load      (load),
      .ld_sync   (sync_fire),
      .ld_kind   (sync_fire ? 3'(K_OTHER) : in_kind),
      .ld_size   (sync_fire ? 2'd0 : in_size),
      .ld_disp   (ld_disp),
      .can_load  (can_load),
      .out_ready (out_ready),
      .out_valid (out_valid),
      .out_sync  (out_sync),
      .out_kind  (out_kind),
      .out_size  (out_size),
      .out_disp  (out_disp)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         delta <= '0;
      else if (flush_valid) delta <= ckpt_val;
      else if (sync_fire) delta <= '0;
      else if (accept)    delta <= next_delta;
   end

   // R4
   sync_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_sync) |-> (out_disp != '0));

   // R5
   sync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sync_fire |=> (delta == '0));

   // R3
   delta_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush_valid && !load) |=> $stable(delta));

   // R9
   sync_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sync_fire |-> !in_ready);

endmodule

// File: tb/test_spt_tracker.sv
`timescale 1ns/1ps
module test_spt_tracker;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0, in_ready;
   logic [2:0]  in_kind = '0;
   logic [1:0]  in_size = '0;
   logic        in_sp_explicit = 1'b0, in_sp_base = 1'b0;
   logic [15:0] in_disp = '0;
   logic        in_is_branch = 1'b0;
   logic [1:0]  in_br_tag = '0;
   logic        flush_valid = 1'b0;
   logic [1:0]  flush_tag = '0;
   logic        out_valid, out_ready = 1'b1, out_sync;
   logic [2:0]  out_kind;
   logic [1:0]  out_size;
   logic [15:0] out_disp;

   int n_chk = 0, n_err = 0, ncap = 0;
   logic        cap_sync [16];
   logic [15:0] cap_disp [16];
   logic [2:0]  cap_kind [16];

   always #2 clk = ~clk;

   spt_tracker i_spt_tracker (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_kind(in_kind), .in_size(in_size), .in_sp_explicit(in_sp_explicit),
      .in_sp_base(in_sp_base), .in_disp(in_disp), .in_is_branch(in_is_branch),
      .in_br_tag(in_br_tag), .flush_valid(flush_valid), .flush_tag(flush_tag),
      .out_valid(out_valid), .out_ready(out_ready), .out_sync(out_sync),
      .out_kind(out_kind), .out_size(out_size), .out_disp(out_disp)
   );

   always @(negedge clk) begin
      if (rst_n && out_valid && out_ready) begin
         if (ncap < 16) begin
            cap_sync[ncap] = out_sync;
            cap_disp[ncap] = out_disp;
            cap_kind[ncap] = out_kind;
         end
         ncap++;
      end
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic reset_dut();
      @(negedge clk);
      rst_n = 1'b0; in_valid = 1'b0; flush_valid = 1'b0; out_ready = 1'b1;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      ncap = 0;
   endtask

   task automatic send(output int edges, input logic [2:0] k, input logic [1:0] sz,
                       input logic ex, input logic bs, input int d,
                       input logic br = 1'b0, input logic [1:0] tg = 2'd0);
      logic r;
      @(negedge clk);
      in_valid = 1'b1; in_kind = k; in_size = sz; in_sp_explicit = ex;
      in_sp_base = bs; in_disp = 16'(d); in_is_branch = br; in_br_tag = tg;
      edges = 0;
      forever begin
         #1 r = in_ready;
         @(posedge clk);
         edges++;
         if (r) break;
         @(negedge clk);
      end
   endtask

   task automatic drain();
      @(negedge clk);
      in_valid = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic t_reset();
      int e;
      reset_dut();
      #1;
      chk("R10", "out_valid after reset", int'(out_valid), 0);
      chk("R10", "in_ready after reset", int'(in_ready), 1);
      send(e, 3'd1, 2'd1, 1'b0, 1'b0, 0);
      drain();
      chk("R10", "first push disp from zero offset", $signed(cap_disp[0]), -4);
   endtask

   task automatic t_push_pop();
      int e;
      reset_dut();
      send(e, 3'd1, 2'd1, 1'b0, 1'b0, 0);
      send(e, 3'd1, 2'd1, 1'b0, 1'b0, 0);
      send(e, 3'd3, 2'd2, 1'b0, 1'b0, 0);
      send(e, 3'd4, 2'd2, 1'b0, 1'b0, 0);
      send(e, 3'd2, 2'd1, 1'b0, 1'b0, 0);
      send(e, 3'd2, 2'd1, 1'b0, 1'b0, 0);
      send(e, 3'd0, 2'd0, 1'b0, 1'b1, 0);
      drain();
      chk("R1", "micro-op count, no stack updates", ncap, 7);
      chk("R1", "second push disp", $signed(cap_disp[1]), -8);
      chk("R1", "call disp", $signed(cap_disp[2]), -16);
      chk("R2", "return disp", $signed(cap_disp[3]), -16);
      chk("R2", "first pop disp", $signed(cap_disp[4]), -8);
      chk("R2", "second pop disp", $signed(cap_disp[5]), -4);
      chk("R2", "offset back to zero", $signed(cap_disp[6]), 0);
      chk("R1", "no sync emitted", int'(cap_sync[0] | cap_sync[1] | cap_sync[2]), 0);
   endtask

   task automatic t_sizes();
      int e;
      reset_dut();
      send(e, 3'd1, 2'd0, 1'b0, 1'b0, 2);
      send(e, 3'd1, 2'd3, 1'b0, 1'b0, 0);
      drain();
      chk("R1", "2-byte push disp", $signed(cap_disp[0]), 0);
      chk("R1", "size code 3 as 8 bytes", $signed(cap_disp[1]), -10);
   endtask

   task automatic t_other();
      int e;
      reset_dut();
      send(e, 3'd1, 2'd1, 1'b0, 1'b0, 0);
      send(e, 3'd0, 2'd1, 1'b0, 1'b1, 12);
      send(e, 3'd0, 2'd1, 1'b0, 1'b0, 12);
      send(e, 3'd6, 2'd1, 1'b0, 1'b1, 0);
      drain();
      chk("R3", "stack-based access patched", $signed(cap_disp[1]), 8);
      chk("R3", "non-stack access unchanged", $signed(cap_disp[2]), 12);
      chk("R3", "unused class keeps offset", $signed(cap_disp[3]), -4);
   endtask

   task automatic t_sync();
      int e, e_sync;
      reset_dut();
      send(e, 3'd1, 2'd1, 1'b0, 1'b0, 0);
      send(e, 3'd1, 2'd1, 1'b0, 1'b0, 0);
      send(e_sync, 3'd0, 2'd1, 1'b1, 1'b0, 5);
      send(e, 3'd1, 2'd1, 1'b0, 1'b0, 0);
      drain();
      chk("R4", "micro-op count with sync", ncap, 5);
      chk("R4", "sync flag", int'(cap_sync[2]), 1);
      chk("R4", "sync carries offset", $signed(cap_disp[2]), -8);
      chk("R4", "sync class", int'(cap_kind[2]), 0);
      chk("R4", "instruction after sync", $signed(cap_disp[3]), 5);
      chk("R4", "instruction is not sync", int'(cap_sync[3]), 0);
      chk("R5", "push after sync from zero", $signed(cap_disp[4]), -4);
      chk("R9", "sync costs one extra edge", e_sync, 2);
   endtask

   task automatic t_nosync();
      int e;
      reset_dut();
      send(e, 3'd0, 2'd1, 1'b1, 1'b0, 7);
      drain();
      chk("R6", "no sync at zero offset", ncap, 1);
      chk("R6", "plain micro-op", int'(cap_sync[0]), 0);
      chk("R6", "accepted in one edge", e, 1);
   endtask

   task automatic t_ovf();
      int e;
      reset_dut();
      for (int i = 0; i < 256; i++) send(e, 3'd1, 2'd2, 1'b0, 1'b0, 0);
      drain();
      ncap = 0;
      send(e, 3'd1, 2'd2, 1'b0, 1'b0, 0);
      drain();
      chk("R7", "wrap forces sync", int'(cap_sync[0]), 1);
      chk("R7", "sync carries full offset", $signed(cap_disp[0]), -2048);
      chk("R7", "push from zero", $signed(cap_disp[1]), -8);
      chk("R7", "two edges", e, 2);
   endtask

   task automatic t_flush_hold();
      int e;
      reset_dut();
      send(e, 3'd1, 2'd1, 1'b0, 1'b0, 0);
      send(e, 3'd0, 2'd0, 1'b0, 1'b0, 0, 1'b1, 2'd2);
      send(e, 3'd1, 2'd1, 1'b0, 1'b0, 0);
      send(e, 3'd1, 2'd1, 1'b0, 1'b0, 0);
      drain();
      out_ready = 1'b0;
      send(e, 3'd1, 2'd1, 1'b0, 1'b0, 0);
      @(negedge clk);
      in_valid = 1'b0;
      repeat (2) @(negedge clk);
      #1;
      chk("R9", "output held", int'(out_valid), 1);
      chk("R9", "held disp stable", $signed(out_disp), -16);
      chk("R9", "input blocked while held", int'(in_ready), 0);
      @(negedge clk);
      flush_valid = 1'b1; flush_tag = 2'd2;
      @(negedge clk);
      flush_valid = 1'b0;
      #1;
      chk("R8", "flush drops held micro-op", int'(out_valid), 0);
      ncap = 0;
      out_ready = 1'b1;
      send(e, 3'd0, 2'd0, 1'b0, 1'b1, 0);
      drain();
      chk("R8", "only post-flush micro-op", ncap, 1);
      chk("R8", "offset restored from checkpoint", $signed(cap_disp[0]), -4);
   endtask

   initial begin
      #400000;
      n_chk++; n_err++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      t_reset();
      t_push_pop();
      t_sizes();
      t_other();
      t_sync();
      t_nosync();
      t_ovf();
      t_flush_hold();
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule